// File: doc/BRIEF.md
# SIMD Register-Region Operand Gather

This block fetches one SIMD source operand out of a byte-addressed file of 256-bit registers. A region descriptor names the first element as a register number plus an element-sized offset inside it. It also gives the element type, a row width and two strides measured in elements. From these the block computes the byte address of every channel up to the execution size. Addresses may run past the end of the first register into the registers that follow. The block then pulls each element out, widens it to a 32-bit lane and gates each lane with a per-channel predicate mask.

A single-cycle `start` pulse presents the descriptor. One clock later the block returns either a lane vector with per-lane enables, or an error flag for a malformed or out-of-range region. The register storage is an internal model with one whole-register write port, so that the surrounding logic or a bench can load it.

Top module: `rgn_gather`

## Requirements
- R1: The origin byte address is `src_reg*32 + src_sub*S`, where the element size S follows `src_type`: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. Byte k of register r sits at bits [8k+7:8k] of that register and has file address r*32+k. An element is read little-endian, so its lowest address holds its least significant byte.
- R2: Channel n reads the element at origin + (n / W)·VS·S + (n mod W)·HS·S. Here W is `src_width`, VS is `src_vstride` and HS is `src_hstride`, and both strides count elements.
- R3: A region whose addresses pass the last byte of a register continues into the next register numbers. An element may itself straddle two registers.
- R4: A 1-byte or 2-byte element is zero-extended to 32 bits when `sign_ext` is 0 and sign-extended when it is 1. A 4-byte element is passed through unchanged.
- R5: The descriptor is rejected when `exec_size` is not 1, 2, 4, 8 or 16, when `src_width` is 0, or when `src_type` is 3. A rejected start gives `out_err`=1 and `out_valid`=0 one cycle later, with all enables and lanes zero.
- R6: If any channel below `exec_size` has a last byte beyond file address 4095 (past register 127), the start is rejected in the same way as R5. This holds even when the predicate disables that channel.
- R7: Lane n is enabled when n < `exec_size` and, if `pred_en` is 1, `pred_flags[n]` is 1. A disabled lane outputs zero on `out_data`.
- R8: Results are registered. `out_valid` or `out_err` is high for exactly the one cycle after each `start` cycle. Back-to-back starts give back-to-back results in order.
- R9: A register written through the write port is seen by every `start` issued in a later cycle.
- R10: After reset, `out_valid`, `out_err` and `out_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one whole register |
| wr_reg | input | 7 | Register number to write |
| wr_data | input | 256 | Register write data |
| start | input | 1 | Descriptor present this cycle |
| src_reg | input | 7 | Origin register number |
| src_sub | input | 5 | Origin offset in elements |
| src_type | input | 2 | Element type: 0 byte, 1 word, 2 dword, 3 reserved |
| src_width | input | 5 | Elements per region row |
| src_vstride | input | 6 | Row-to-row step in elements |
| src_hstride | input | 6 | Element-to-element step in elements |
| exec_size | input | 5 | Channel count |
| sign_ext | input | 1 | Sign-extend narrow elements |
| pred_en | input | 1 | Apply predicate mask |
| pred_flags | input | 16 | Per-channel predicate bits |
| out_valid | output | 1 | Lane vector valid |
| out_err | output | 1 | Descriptor rejected |
| out_en | output | 16 | Per-lane enable |
| out_data | output | 512 | Lane n at bits [32n+31:32n] |

## Verification
The bench starts with the word region of width 8, vertical stride 16 and horizontal stride 2 at register 5, offset 2. In that region the second row falls into register 6. A design that ignored the vertical stride or wrapped inside one register would return row 0 again. Narrow elements with the top bit set are read both signed and unsigned, which catches a swapped or missing extension. A region that ends exactly on byte 4095 must pass, and the same region one element later must fail, which exposes an off-by-one in the range test. A channel that the predicate disables but that lies out of range must still raise the error. Broadcast rows (vertical stride 0), odd execution sizes, width zero, the reserved type and back-to-back starts are also covered. A design that mishandled these would show stale, shifted or missing results in the scoreboard.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

   typedef enum logic [1:0] {
      ET_BYTE  = 2'd0,
      ET_WORD  = 2'd1,
      ET_DWORD = 2'd2,
      ET_RSVD  = 2'd3
   } elem_t;

   localparam int LANE_BITS = 32;

   // log2 of element size in bytes
   function automatic logic [1:0] elem_shift(elem_t t);
      case (t)
         ET_BYTE: return 2'd0;
         ET_WORD: return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/rgn_regfile.sv
module rgn_regfile #(
   parameter int NUM_REGS  = 128,
   parameter int REG_BYTES = 32,
   parameter int NRD       = 64,
   localparam int REG_IDX_W  = $clog2(NUM_REGS),
   localparam int BYTE_IDX_W = $clog2(REG_BYTES),
   localparam int FILE_AW    = REG_IDX_W + BYTE_IDX_W
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [REG_IDX_W-1:0]     wr_reg,
   input  logic [REG_BYTES*8-1:0]   wr_data,
   input  logic [FILE_AW-1:0]       raddr [NRD],
   output logic [7:0]               rdata [NRD]
);

   logic [REG_BYTES*8-1:0] regs [NUM_REGS];

   always_ff @(posedge clk) begin
      if (wr_en) regs[wr_reg] <= wr_data;
   end

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      logic [REG_IDX_W-1:0]  r_idx;
      logic [BYTE_IDX_W-1:0] b_idx;
      assign r_idx    = raddr[k][FILE_AW-1:BYTE_IDX_W];
      assign b_idx    = raddr[k][BYTE_IDX_W-1:0];
      assign rdata[k] = regs[r_idx][b_idx*8 +: 8];
   end

endmodule

// File: rtl/rgn_addr_gen.sv
module rgn_addr_gen #(
   parameter int MAX_LANES  = 16,
   parameter int WIDTH_W    = 5,
   parameter int STRIDE_W   = 6,
   parameter int SUB_W      = 5,
   parameter int REG_IDX_W  = 7,
   parameter int BYTE_IDX_W = 5,
   parameter int ADDR_W     = 15,
   parameter int FILE_BYTES = 4096
) (
   input  logic [REG_IDX_W-1:0] reg_num,
   input  logic [SUB_W-1:0]     sub,
   input  logic [1:0]           shift,
   input  logic [WIDTH_W-1:0]   width,
   input  logic [STRIDE_W-1:0]  vstride,
   input  logic [STRIDE_W-1:0]  hstride,
   input  logic [MAX_LANES-1:0] live,
   output logic [ADDR_W-1:0]    addr [MAX_LANES],
   output logic                 range_bad
);

   logic [ADDR_W-1:0]  origin;
   logic [ADDR_W-1:0]  last;
   logic [WIDTH_W-1:0] col;
   logic [ADDR_W-1:0]  row;

   // column/row walk: a chain of compares instead of a divider per lane
   always_comb begin
      origin    = (ADDR_W'(reg_num) << BYTE_IDX_W) + (ADDR_W'(sub) << shift);
      col       = '0;
      row       = '0;
      range_bad = 1'b0;
      last      = '0;
      for (int n = 0; n < MAX_LANES; n++) begin
         if (n > 0) begin
            if (WIDTH_W'(col + 1'b1) == width) begin
               col = '0;
               row = row + 1'b1;
            end else begin
               col = WIDTH_W'(col + 1'b1);
            end
         end
         addr[n] = origin
                 + ((row * ADDR_W'(vstride)) << shift)
                 + ((ADDR_W'(col) * ADDR_W'(hstride)) << shift);
         last = addr[n] + ((ADDR_W'(1) << shift) - 1'b1);
         if (live[n] && (last >= ADDR_W'(FILE_BYTES))) range_bad = 1'b1;
      end
   end

endmodule

// File: rtl/rgn_lane_extract.sv
module rgn_lane_extract
   import rgn_pkg::*;
(
   input  elem_t                 etype,
   input  logic                  sign_ext,
   input  logic                  enable,
   input  logic [31:0]           raw,
   output logic [LANE_BITS-1:0]  value
);

   logic [LANE_BITS-1:0] widened;

   always_comb begin
      case (etype)
         ET_BYTE: widened = {{24{sign_ext & raw[7]}}, raw[7:0]};
         ET_WORD: widened = {{16{sign_ext & raw[15]}}, raw[15:0]};
         default: widened = raw;
      endcase
      value = enable ? widened : '0;
   end

endmodule

// File: rtl/rgn_gather.sv
module rgn_gather
   import rgn_pkg::*;
#(
   parameter int NUM_REGS  = 128,
   parameter int REG_BYTES = 32,
   parameter int MAX_LANES = 16,
   parameter int SUB_W     = 5,
   parameter int STRIDE_W  = 6,
   localparam int REG_IDX_W  = $clog2(NUM_REGS),
   localparam int BYTE_IDX_W = $clog2(REG_BYTES),
   localparam int FILE_BYTES = NUM_REGS * REG_BYTES,
   localparam int FILE_AW    = REG_IDX_W + BYTE_IDX_W,
   localparam int CNT_W      = $clog2(MAX_LANES) + 1,
   localparam int ADDR_W     = $clog2(FILE_BYTES + (2**SUB_W) * 4
                                      + 2 * MAX_LANES * (2**STRIDE_W) * 4) + 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [REG_IDX_W-1:0]            wr_reg,
   input  logic [REG_BYTES*8-1:0]          wr_data,
   input  logic                            start,
   input  logic [REG_IDX_W-1:0]            src_reg,
   input  logic [SUB_W-1:0]                src_sub,
   input  logic [1:0]                      src_type,
   input  logic [CNT_W-1:0]                src_width,
   input  logic [STRIDE_W-1:0]             src_vstride,
   input  logic [STRIDE_W-1:0]             src_hstride,
   input  logic [CNT_W-1:0]                exec_size,
   input  logic                            sign_ext,
   input  logic                            pred_en,
   input  logic [MAX_LANES-1:0]            pred_flags,
   output logic                            out_valid,
   output logic                            out_err,
   output logic [MAX_LANES-1:0]            out_en,
   output logic [MAX_LANES*LANE_BITS-1:0]  out_data
);

   localparam int NRD = MAX_LANES * 4;

   // elaboration-time parameter checks
   if ((NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_chk_regs
      $error("NUM_REGS must be a power of two");
   end
   if ((REG_BYTES & (REG_BYTES - 1)) != 0 || REG_BYTES < 4) begin : g_chk_rbytes
      $error("REG_BYTES must be a power of two of at least 4");
   end
   if ((MAX_LANES & (MAX_LANES - 1)) != 0) begin : g_chk_lanes
      $error("MAX_LANES must be a power of two");
   end

   elem_t                etype;
   logic [1:0]           shift;
   logic                 exec_ok;
   logic                 desc_bad;
   logic                 range_bad;
   logic                 bad;
   logic [MAX_LANES-1:0] live;
   logic [MAX_LANES-1:0] en_next;
   logic [ADDR_W-1:0]    lane_addr [MAX_LANES];
   logic [FILE_AW-1:0]   raddr [NRD];
   logic [7:0]           rdata [NRD];
   logic [MAX_LANES*LANE_BITS-1:0] data_next;

   assign etype    = elem_t'(src_type);
   assign shift    = elem_shift(etype);
   assign exec_ok  = (exec_size != '0) && ((exec_size & (exec_size - 1'b1)) == '0)
                     && (exec_size <= CNT_W'(MAX_LANES));
   assign desc_bad = !exec_ok || (src_width == '0) || (etype == ET_RSVD);
   assign bad      = desc_bad || range_bad;

   rgn_addr_gen #(
      .MAX_LANES (MAX_LANES), .WIDTH_W (CNT_W), .STRIDE_W (STRIDE_W),
      .SUB_W (SUB_W), .REG_IDX_W (REG_IDX_W), .BYTE_IDX_W (BYTE_IDX_W),
      .ADDR_W (ADDR_W), .FILE_BYTES (FILE_BYTES)
   ) u_addr (
      .reg_num (src_reg), .sub (src_sub), .shift (shift), .width (src_width),
      .vstride (src_vstride), .hstride (src_hstride), .live (live),
      .addr (lane_addr), .range_bad (range_bad)
   );

   rgn_regfile #(
      .NUM_REGS (NUM_REGS), .REG_BYTES (REG_BYTES), .NRD (NRD)
   ) u_rf (
      .clk (clk), .wr_en (wr_en), .wr_reg (wr_reg), .wr_data (wr_data),
      .raddr (raddr), .rdata (rdata)
   );

   for (genvar n = 0; n < MAX_LANES; n++) begin : g_lane
      logic [31:0] raw;
      assign live[n]    = (CNT_W'(n) < exec_size);
      assign en_next[n] = live[n] && (!pred_en || pred_flags[n]) && !bad;
      for (genvar k = 0; k < 4; k++) begin : g_byte
         assign raddr[n*4+k]    = FILE_AW'(lane_addr[n] + ADDR_W'(k));
         assign raw[k*8 +: 8]   = rdata[n*4+k];
      end
      rgn_lane_extract u_ext (
         .etype (etype), .sign_ext (sign_ext), .enable (en_next[n]),
         .raw (raw), .value (data_next[n*LANE_BITS +: LANE_BITS])
      );

      AST_OFF_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !out_en[n] |-> out_data[n*LANE_BITS +: LANE_BITS] == '0);   // R7
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_en    <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= start && !bad;
         out_err   <= start && bad;
         if (start) begin
            out_en   <= en_next;
            out_data <= data_next;
         end
      end
   end

   AST_RESULT_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || out_err) |-> $past(start));                        // R8
   AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_err));                                        // R5
   AST_ERR_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_en == '0);                                       // R6
   AST_PRED_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(pred_en)) |-> (out_en & ~$past(pred_flags)) == '0);   // R7
   AST_EN_WITHIN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_en) <= int'($past(exec_size)));      // R7

endmodule

// File: tb/rgn_gather_test.sv
module rgn_gather_test;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic         err;
      logic [15:0]  en;
      logic [511:0] data;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [6:0]   wr_reg = '0;
   logic [255:0] wr_data = '0;
   logic         start = 1'b0;
   logic [6:0]   src_reg = '0;
   logic [4:0]   src_sub = '0;
   logic [1:0]   src_type = '0;
   logic [4:0]   src_width = '0;
   logic [5:0]   src_vstride = '0;
   logic [5:0]   src_hstride = '0;
   logic [4:0]   exec_size = '0;
   logic         sign_ext = 1'b0;
   logic         pred_en = 1'b0;
   logic [15:0]  pred_flags = '0;
   logic         out_valid;
   logic         out_err;
   logic [15:0]  out_en;
   logic [511:0] out_data;

   int   total = 0;
   int   bad_cnt = 0;
   bit   done = 1'b0;
   logic [7:0] mem [4096];
   exp_t  exp_q [$];
   string tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rgn_gather uut (
      .clk, .rst_n, .wr_en, .wr_reg, .wr_data, .start, .src_reg, .src_sub,
      .src_type, .src_width, .src_vstride, .src_hstride, .exec_size,
      .sign_ext, .pred_en, .pred_flags, .out_valid, .out_err, .out_en, .out_data
   );

   function automatic logic [7:0] pat(int a, int seed);
      return 8'((a * 29) ^ (a >> 5) ^ (seed * 83) ^ 7);
   endfunction

   task automatic load_reg(int r, int seed);
      @(negedge clk);
      wr_en  = 1'b1;
      wr_reg = 7'(r);
      for (int k = 0; k < 32; k++) begin
         mem[r*32+k]      = pat(r*32+k, seed);
         wr_data[k*8 +: 8] = mem[r*32+k];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: computes expected result from the requirements and issues it
   task automatic issue(string tag, int r, int sub, int et, int w, int vs,
                        int hs, int ex, bit se, bit pe, logic [15:0] flg);
      exp_t e;
      int   sz;
      bit   bad;
      e  = '0;
      sz = (et == 0) ? 1 : (et == 1) ? 2 : 4;
      bad = (et == 3) || (w == 0) || !(ex == 1 || ex == 2 || ex == 4 || ex == 8 || ex == 16);
      if (!bad) begin
         for (int n = 0; n < ex; n++) begin
            int a;
            a = r*32 + sub*sz + (n / w)*vs*sz + (n % w)*hs*sz;
            if (a + sz - 1 > 4095) bad = 1'b1;
         end
      end
      if (!bad) begin
         for (int n = 0; n < ex; n++) begin
            int a;
            logic [31:0] v;
            a = r*32 + sub*sz + (n / w)*vs*sz + (n % w)*hs*sz;
            v = '0;
            for (int k = 0; k < sz; k++) v[k*8 +: 8] = mem[a+k];
            if (se && sz == 1) v = {{24{v[7]}}, v[7:0]};
            if (se && sz == 2) v = {{16{v[15]}}, v[15:0]};
            if (!pe || flg[n]) begin
               e.en[n] = 1'b1;
               e.data[n*32 +: 32] = v;
            end
         end
      end
      e.err = bad;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      src_reg = 7'(r); src_sub = 5'(sub); src_type = 2'(et); src_width = 5'(w);
      src_vstride = 6'(vs); src_hstride = 6'(hs); exec_size = 5'(ex);
      sign_ext = se; pred_en = pe; pred_flags = flg;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic chk(string tag, string what, logic [511:0] act, logic [511:0] expv);
      total++;
      if (act !== expv) begin
         bad_cnt++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // monitor: pops the scoreboard whenever a result appears
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && (out_valid || out_err)) begin
            if (exp_q.size() == 0) begin
               chk("R8", "unexpected result", {510'd0, out_valid, out_err}, '0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, "valid/err", {510'd0, out_valid, out_err}, {510'd0, !e.err, e.err});
               chk(t, "lane enables", {496'd0, out_en}, {496'd0, e.en});
               chk(t, "lane data", out_data, e.data);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "reset state", {495'd0, out_valid, out_err, out_en}, '0);

      for (int r = 0; r < 128; r++) load_reg(r, 0);

      // R2 R3: region example, second row lands in the next register
      issue("R2", 5, 2, 1, 8, 16, 2, 16, 1'b0, 1'b0, 16'h0000);
      // R1: byte region, unsigned then signed (R4)
      issue("R1", 10, 3, 0, 4, 8, 1, 8, 1'b0, 1'b0, 16'h0000);
      issue("R4", 10, 3, 0, 4, 8, 1, 8, 1'b1, 1'b0, 16'h0000);
      issue("R4", 20, 7, 1, 2, 5, 3, 16, 1'b1, 1'b0, 16'h0000);
      // R3: dword region spanning several registers
      issue("R3", 30, 6, 2, 4, 16, 3, 16, 1'b0, 1'b0, 16'h0000);
      // R2: broadcast rows with vertical stride zero
      issue("R2", 40, 1, 1, 4, 0, 1, 16, 1'b0, 1'b0, 16'h0000);
      // R7: predication and partial execution size
      issue("R7", 50, 0, 1, 8, 8, 1, 16, 1'b0, 1'b1, 16'hA5C3);
      issue("R7", 50, 0, 0, 16, 16, 1, 8, 1'b1, 1'b1, 16'hFFFF);
      issue("R7", 60, 4, 2, 1, 1, 0, 1, 1'b0, 1'b0, 16'h0000);
      // R5: malformed descriptors
      issue("R5", 5, 0, 1, 0, 1, 1, 8, 1'b0, 1'b0, 16'h0000);
      issue("R5", 5, 0, 1, 4, 4, 1, 3, 1'b0, 1'b0, 16'h0000);
      issue("R5", 5, 0, 1, 4, 4, 1, 0, 1'b0, 1'b0, 16'h0000);
      issue("R5", 5, 0, 3, 4, 4, 1, 4, 1'b0, 1'b0, 16'h0000);
      issue("R5", 5, 0, 1, 4, 4, 1, 12, 1'b0, 1'b0, 16'h0000);
      // R6: ends exactly on the last byte, then one element past it
      issue("R6", 127, 0, 1, 16, 16, 1, 16, 1'b0, 1'b0, 16'h0000);
      issue("R6", 127, 1, 1, 16, 16, 1, 16, 1'b0, 1'b1, 16'h7FFF);
      // R8: back-to-back starts, then a gap
      issue("R8", 70, 0, 0, 8, 8, 1, 16, 1'b0, 1'b0, 16'h0000);
      issue("R8", 71, 5, 1, 4, 6, 2, 8, 1'b1, 1'b0, 16'h0000);
      @(negedge clk);
      // R9: rewrite origin registers and gather again
      load_reg(5, 1);
      load_reg(6, 1);
      issue("R9", 5, 2, 1, 8, 16, 2, 16, 1'b0, 1'b0, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R8", "scoreboard drained", {480'd0, 32'(exp_q.size())}, '0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad_cnt++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad_cnt);
         $finish;
      end
   end

endmodule